// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Engine

This block keeps the buffer descriptor table of an Ethernet controller in local storage and runs the transmit and receive rings over it. Software builds each descriptor through a 32-bit register port and can read it back. A descriptor is a pair of words: a control/status word and a buffer address. One table holds both rings. The first N entries form the transmit ring and the rest form the receive ring, where N is a programmable count.

On the transmit side, the engine waits on the current descriptor until software marks it ready. It then presents the frame length (raised to the minimum frame size when padding is requested) and the buffer address to an abstract transmitter. When the transmitter reports completion, the engine writes the outcome back into the descriptor. On the receive side, each frame reported by an abstract receiver is placed in the current descriptor if that descriptor is empty. The engine then writes back the received length and flags. If the descriptor is not empty, the frame is dropped and a drop event is raised. Events are collected in a sticky source register. The interrupt line is the OR of the sources that are enabled in a mask register.

Top module: `bd_ring_engine`

## Requirements
- R1: After reset the control word reads 0 (both rings disabled), the transmit count reads 0x40, the source and mask registers read 0, every descriptor word reads 0, and `irq` and `tx_req` are low.
- R2: The transmit count is at byte offset 0x20. A written value above 128 is stored and read back as 128. The receive ring starts at index N, and when N is 128 every received frame is dropped with the drop event (source bit 4).
- R3: Descriptor i is at byte offset 0x400 + 8*i. Its control/status word is at +0 and its buffer address at +4, and both read back what was written.
- R4: When the current transmit descriptor has READY (bit 15) set and transmit is enabled, `tx_req` rises one cycle later. With it, `tx_addr` and `tx_len` are presented: the length is bits 31:16, or 64 if PAD (bit 12) is set and the length is below 64. Both stay stable until `tx_done`.
- R5: On `tx_done`, the descriptor's bit 15 is cleared and bits 8:0 are replaced by `tx_result`. All other bits are kept.
- R6: A transmit completion on a descriptor with IRQ (bit 14) set raises source bit 0 when `tx_result` bits 8 and 3:0 are all zero, and source bit 1 otherwise. With IRQ clear it raises nothing. A `tx_ctl_sent` pulse raises source bit 5.
- R7: A transmit descriptor that is not READY stalls the ring. Later descriptors that are READY are not served until it is.
- R8: After serving a descriptor with WRAP (bit 13) set, or the last slot of its ring, the pointer returns to the ring's first descriptor.
- R9: A received frame lands in the current receive descriptor if that descriptor's EMPTY bit (15) is set. The write-back puts `rx_len` in bits 31:16, clears bit 15, keeps bits 14:9 and puts `rx_flags` in bits 8:0.
- R10: A received frame on a descriptor with IRQ set raises source bit 2 when `rx_flags` bits 7:0 are zero, and source bit 3 otherwise. It also raises source bit 6 when `rx_flags` bit 8 is set. A frame that meets a non-empty descriptor changes no descriptor and raises source bit 4.
- R11: Source bits (offset 0x04) latch regardless of the mask (offset 0x08). Writing 1 to a source bit clears it and writing 0 leaves it. `irq` is high exactly when some source bit and its mask bit are both set.
- R12: The control word is at offset 0x00, with bit 0 enabling receive and bit 1 enabling transmit. Clearing an enable bit returns that ring's pointer to its first descriptor. Frames received while receive is disabled change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Register port write strobe |
| host_addr | input | ADDR_W | Register port byte address |
| host_wdata | input | 32 | Register port write data |
| host_rdata | output | 32 | Register port read data (combinational) |
| tx_req | output | 1 | Transmit job pending |
| tx_len | output | 16 | Length to transmit (padded if requested) |
| tx_addr | output | 32 | Buffer address of the transmit job |
| tx_done | input | 1 | Transmitter finished the current job |
| tx_result | input | 9 | Transmit outcome flags for status bits 8:0 |
| tx_ctl_sent | input | 1 | A control frame has been sent |
| rx_valid | input | 1 | A received frame is complete |
| rx_len | input | 16 | Received length including the 4 CRC bytes |
| rx_flags | input | 9 | Receive flags for status bits 8:0 |
| irq | output | 1 | Interrupt request |

## Verification
Every result has a fixed due cycle, and each check samples on the falling edge after it:
- A register write is visible on a read in the following cycle.
- A descriptor made READY by a write at edge k drives `tx_req` after edge k+1. The next queued job follows one edge after the completion edge.
- A `tx_done` or `rx_valid` pulse sampled at an edge updates the descriptor and the source register at that same edge.
- `irq` follows the sources and mask without further delay.

The checks that stalls and wraps work confirm that `tx_req` stays low over several cycles where a skipping or non-wrapping pointer would already have started a job.

// File: rtl/bdr_pkg.sv
// Package bdr_pkg
// Shared constants for the descriptor ring engine: register offsets,
// control/status bit positions and interrupt source bit positions.
// Assumes a byte-addressed, word-aligned register port.
package bdr_pkg;

    // register offsets (bytes)
    localparam logic [31:0] OFF_CTRL  = 32'h000;
    localparam logic [31:0] OFF_ISRC  = 32'h004;
    localparam logic [31:0] OFF_IMSK  = 32'h008;
    localparam logic [31:0] OFF_TXCNT = 32'h020;
    localparam logic [31:0] OFF_TABLE = 32'h400;

    // control/status word bit positions
    localparam int ST_OWN   = 15;  // READY on transmit, EMPTY on receive
    localparam int ST_IRQ   = 14;
    localparam int ST_WRAP  = 13;
    localparam int ST_PAD   = 12;
    localparam int LEN_LSB  = 16;
    localparam int FLAG_W   = 9;   // bits 8:0 written back by the engine

    // interrupt source bit positions
    localparam int EV_TXF  = 0;
    localparam int EV_TXE  = 1;
    localparam int EV_RXF  = 2;
    localparam int EV_RXE  = 3;
    localparam int EV_BUSY = 4;
    localparam int EV_TXC  = 5;
    localparam int EV_RXC  = 6;
    localparam int EV_W    = 7;

    localparam int MIN_FRAME = 64;

    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

endpackage

// File: rtl/bdr_regs.sv
// Module bdr_regs
// Holds the control word (ring enables), the transmit descriptor count,
// the sticky interrupt source register and the interrupt mask, and drives
// the interrupt line. Event pulses set source bits; a host write of 1
// clears them, with a same-cycle set taking precedence.
// Assumes exact word-aligned addresses for register hits.
module bdr_regs
    import bdr_pkg::*;
#(
    parameter int MAX_BD = 128,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    input  logic [EV_W-1:0]   ev_set,
    output logic              tx_en,
    output logic              rx_en,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic [EV_W-1:0]   int_src,
    output logic [EV_W-1:0]   int_msk,
    output logic              irq,
    output logic [31:0]       reg_rdata
);

    localparam logic [CNT_W-1:0] CNT_RESET = CNT_W'(MAX_BD / 2);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_BD);

    logic hit_ctrl, hit_isrc, hit_imsk, hit_txcnt;

    assign hit_ctrl  = (host_addr == ADDR_W'(OFF_CTRL));
    assign hit_isrc  = (host_addr == ADDR_W'(OFF_ISRC));
    assign hit_imsk  = (host_addr == ADDR_W'(OFF_IMSK));
    assign hit_txcnt = (host_addr == ADDR_W'(OFF_TXCNT));

    // Ring enable bits: bit 0 receive, bit 1 transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
        end else if (host_we && hit_ctrl) begin
            rx_en <= host_wdata[0];
            tx_en <= host_wdata[1];
        end
    end

    // Transmit descriptor count, clamped to the table size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt <= CNT_RESET;
        end else if (host_we && hit_txcnt) begin
            tx_cnt <= (host_wdata > 32'(MAX_BD)) ? CNT_LIMIT : host_wdata[CNT_W-1:0];
        end
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_msk <= '0;
        end else if (host_we && hit_imsk) begin
            int_msk <= host_wdata[EV_W-1:0];
        end
    end

    // One sticky flop per source bit: set by events, cleared by write-1.
    for (genvar b = 0; b < EV_W; b++) begin : g_src
        logic src_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q <= 1'b0;
            end else if (ev_set[b]) begin
                src_q <= 1'b1;
            end else if (host_we && hit_isrc && host_wdata[b]) begin
                src_q <= 1'b0;
            end
        end
        assign int_src[b] = src_q;
    end

    assign irq = |(int_src & int_msk);

    // Register read-back mux.
    always_comb begin
        if (hit_ctrl) begin
            reg_rdata = {30'd0, tx_en, rx_en};
        end else if (hit_isrc) begin
            reg_rdata = 32'(int_src);
        end else if (hit_imsk) begin
            reg_rdata = 32'(int_msk);
        end else if (hit_txcnt) begin
            reg_rdata = 32'(tx_cnt);
        end else begin
            reg_rdata = '0;
        end
    end

    // R11
    src_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && hit_isrc) |=> ((int_src & $past(int_src)) == $past(int_src)));

endmodule

// File: rtl/bdr_table.sv
// Module bdr_table
// Storage for MAX_BD descriptors (control/status word and buffer address).
// The host writes either word. The transmit and receive engines write back
// control/status words only, and win over a host write to the same word in
// the same cycle. All reads are combinational.
// Assumes the transmit and receive write-back indices never coincide.
module bdr_table
    import bdr_pkg::*;
#(
    parameter int MAX_BD = 128,
    parameter int IDX_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we_stat,
    input  logic             host_we_addr,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_stat,
    output logic [31:0]      host_baddr,
    input  logic [IDX_W-1:0] tx_idx,
    input  logic             tx_wb,
    input  logic [31:0]      tx_wb_val,
    output logic [31:9]      tx_hi,
    output logic [31:0]      tx_baddr,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic             rx_wb,
    input  logic [31:0]      rx_wb_val,
    output logic [15:9]      rx_ctl
);

    logic [31:0] stat_q [MAX_BD];
    logic [31:0] addr_q [MAX_BD];

    // Control/status words: later assignments give engines priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_BD; i++) stat_q[i] <= '0;
        end else begin
            if (host_we_stat) stat_q[host_idx] <= host_wdata;
            if (rx_wb)        stat_q[rx_idx]   <= rx_wb_val;
            if (tx_wb)        stat_q[tx_idx]   <= tx_wb_val;
        end
    end

    // Buffer address words: host-written only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_BD; i++) addr_q[i] <= '0;
        end else if (host_we_addr) begin
            addr_q[host_idx] <= host_wdata;
        end
    end

    logic [31:0] tx_word, rx_word;

    // Read ports for host and both engines.
    always_comb begin
        host_stat  = stat_q[host_idx];
        host_baddr = addr_q[host_idx];
        tx_word    = stat_q[tx_idx];
        tx_baddr   = addr_q[tx_idx];
        rx_word    = stat_q[rx_idx];
        tx_hi      = tx_word[31:9];
        rx_ctl     = rx_word[15:9];
    end

    // R5
    tx_wb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wb |-> stat_q[tx_idx][ST_OWN]);

    // R9
    rx_wb_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wb |-> stat_q[rx_idx][ST_OWN]);

endmodule

// File: rtl/bdr_tx.sv
// Module bdr_tx
// Transmit ring walker. It waits on the current descriptor until it is
// READY, presents length and address to the transmitter, and on completion
// writes back status, raises events and advances the pointer. The pointer
// wraps on the WRAP flag or after the last transmit slot.
// Assumes tx_done pulses only while tx_req is high.
module bdr_tx
    import bdr_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [31:9]       cur_hi,
    input  logic [31:0]       cur_baddr,
    input  logic              tx_done,
    input  logic [FLAG_W-1:0] tx_result,
    input  logic              tx_ctl_sent,
    output logic [IDX_W-1:0]  tx_ptr,
    output logic              tx_req,
    output logic [15:0]       tx_len,
    output logic [31:0]       tx_addr,
    output logic              wb,
    output logic [31:0]       wb_val,
    output logic [EV_W-1:0]   ev
);

    tx_state_e   state;
    logic        load, is_err, at_last, pad_up;
    logic [15:0] cur_len;

    assign cur_len = cur_hi[31:LEN_LSB];
    assign pad_up  = cur_hi[ST_PAD] && (cur_len < 16'(MIN_FRAME));
    assign load    = (state == TX_IDLE) && tx_en && (tx_cnt != '0) && cur_hi[ST_OWN];
    assign wb      = (state == TX_SEND) && tx_en && tx_done;
    assign at_last = ((CNT_W'(tx_ptr) + CNT_W'(1)) >= tx_cnt);
    assign is_err  = tx_result[8] | (|tx_result[3:0]);

    // State and ring pointer; a cleared enable returns both to the start.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            state  <= TX_IDLE;
            tx_ptr <= '0;
        end else if (load) begin
            state <= TX_SEND;
        end else if (wb) begin
            state  <= TX_IDLE;
            tx_ptr <= (cur_hi[ST_WRAP] || at_last) ? '0 : tx_ptr + 1'b1;
        end
    end

    // Job fields captured when a descriptor is picked up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_len  <= '0;
            tx_addr <= '0;
        end else if (load) begin
            tx_len  <= pad_up ? 16'(MIN_FRAME) : cur_len;
            tx_addr <= cur_baddr;
        end
    end

    assign tx_req = (state == TX_SEND);
    assign wb_val = {cur_hi[31:16], 1'b0, cur_hi[14:9], tx_result};

    // Event pulses for the source register.
    always_comb begin
        ev         = '0;
        ev[EV_TXF] = wb && cur_hi[ST_IRQ] && !is_err;
        ev[EV_TXE] = wb && cur_hi[ST_IRQ] && is_err;
        ev[EV_TXC] = tx_ctl_sent;
    end

    // R4
    tx_job_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done && tx_en) |=> (tx_req && $stable(tx_len) && $stable(tx_addr)));

endmodule

// File: rtl/bdr_rx.sv
// Module bdr_rx
// Receive ring handler. Each completed frame claims the current receive
// descriptor if it is EMPTY: length and flags are written back and the
// pointer advances, wrapping on WRAP or at the table end. Otherwise the
// frame is dropped with a drop event.
// Assumes rx_valid is a one-cycle pulse per frame.
module bdr_rx
    import bdr_pkg::*;
#(
    parameter int MAX_BD = 128,
    parameter int IDX_W  = 7,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [15:9]       cur_ctl,
    input  logic              rx_valid,
    input  logic [15:0]       rx_len,
    input  logic [FLAG_W-1:0] rx_flags,
    output logic [IDX_W-1:0]  rx_idx,
    output logic              wb,
    output logic [31:0]       wb_val,
    output logic [EV_W-1:0]   ev
);

    logic [IDX_W-1:0] rx_ptr;
    logic [CNT_W-1:0] idx_full;
    logic             has_ring, take, drop, is_err, at_end;

    assign idx_full = tx_cnt + CNT_W'(rx_ptr);
    assign rx_idx   = idx_full[IDX_W-1:0];
    assign has_ring = (tx_cnt < CNT_W'(MAX_BD));
    assign take     = rx_valid && rx_en && has_ring && cur_ctl[ST_OWN];
    assign drop     = rx_valid && rx_en && !(has_ring && cur_ctl[ST_OWN]);
    assign at_end   = (idx_full == CNT_W'(MAX_BD - 1));
    assign is_err   = |rx_flags[7:0];

    // Ring pointer, cleared while receive is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            rx_ptr <= '0;
        end else if (take) begin
            rx_ptr <= (cur_ctl[ST_WRAP] || at_end) ? '0 : rx_ptr + 1'b1;
        end
    end

    assign wb     = take;
    assign wb_val = {rx_len, 1'b0, cur_ctl[14:9], rx_flags};

    // Event pulses for the source register.
    always_comb begin
        ev          = '0;
        ev[EV_RXF]  = take && cur_ctl[ST_IRQ] && !is_err;
        ev[EV_RXE]  = take && cur_ctl[ST_IRQ] && is_err;
        ev[EV_RXC]  = take && cur_ctl[ST_IRQ] && rx_flags[8];
        ev[EV_BUSY] = drop;
    end

endmodule

// File: rtl/bd_ring_engine.sv
// Module bd_ring_engine
// Top of the descriptor ring engine. It decodes the host register port
// between control registers and the descriptor table, and connects the
// table to the transmit walker and the receive handler.
// Assumes OFF_TABLE is aligned to the table size (8 * MAX_BD bytes).
module bd_ring_engine
    import bdr_pkg::*;
#(
    parameter int MAX_BD = 128,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              tx_req,
    output logic [15:0]       tx_len,
    output logic [31:0]       tx_addr,
    input  logic              tx_done,
    input  logic [8:0]        tx_result,
    input  logic              tx_ctl_sent,
    input  logic              rx_valid,
    input  logic [15:0]       rx_len,
    input  logic [8:0]        rx_flags,
    output logic              irq
);

    localparam int          IDX_W   = $clog2(MAX_BD);
    localparam int          CNT_W   = IDX_W + 1;
    localparam logic [31:0] TBL_END = OFF_TABLE + 32'(8 * MAX_BD);

    logic             tx_en, rx_en;
    logic [CNT_W-1:0] tx_cnt;
    logic [EV_W-1:0]  int_src, int_msk, tx_ev, rx_ev;
    logic [31:0]      reg_rdata, host_stat, host_baddr, tx_baddr;
    logic [31:0]      tx_wb_val, rx_wb_val;
    logic [31:9]      tx_hi;
    logic [15:9]      rx_ctl;
    logic [IDX_W-1:0] host_idx, tx_ptr, rx_idx;
    logic             tbl_hit, tx_wb, rx_wb;

    // Host address decode into the descriptor table.
    assign tbl_hit  = (32'(host_addr) >= OFF_TABLE) && (32'(host_addr) < TBL_END)
                      && (host_addr[1:0] == 2'b00);
    assign host_idx = host_addr[IDX_W+2:3];

    assign host_rdata = tbl_hit ? (host_addr[2] ? host_baddr : host_stat) : reg_rdata;

    bdr_regs #(
        .MAX_BD (MAX_BD),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .ev_set     (tx_ev | rx_ev),
        .tx_en      (tx_en),
        .rx_en      (rx_en),
        .tx_cnt     (tx_cnt),
        .int_src    (int_src),
        .int_msk    (int_msk),
        .irq        (irq),
        .reg_rdata  (reg_rdata)
    );

    bdr_table #(
        .MAX_BD (MAX_BD),
        .IDX_W  (IDX_W)
    ) i_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we_stat (host_we && tbl_hit && !host_addr[2]),
        .host_we_addr (host_we && tbl_hit && host_addr[2]),
        .host_idx     (host_idx),
        .host_wdata   (host_wdata),
        .host_stat    (host_stat),
        .host_baddr   (host_baddr),
        .tx_idx       (tx_ptr),
        .tx_wb        (tx_wb),
        .tx_wb_val    (tx_wb_val),
        .tx_hi        (tx_hi),
        .tx_baddr     (tx_baddr),
        .rx_idx       (rx_idx),
        .rx_wb        (rx_wb),
        .rx_wb_val    (rx_wb_val),
        .rx_ctl       (rx_ctl)
    );

    bdr_tx #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .tx_cnt      (tx_cnt),
        .cur_hi      (tx_hi),
        .cur_baddr   (tx_baddr),
        .tx_done     (tx_done),
        .tx_result   (tx_result),
        .tx_ctl_sent (tx_ctl_sent),
        .tx_ptr      (tx_ptr),
        .tx_req      (tx_req),
        .tx_len      (tx_len),
        .tx_addr     (tx_addr),
        .wb          (tx_wb),
        .wb_val      (tx_wb_val),
        .ev          (tx_ev)
    );

    bdr_rx #(
        .MAX_BD (MAX_BD),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .tx_cnt   (tx_cnt),
        .cur_ctl  (rx_ctl),
        .rx_valid (rx_valid),
        .rx_len   (rx_len),
        .rx_flags (rx_flags),
        .rx_idx   (rx_idx),
        .wb       (rx_wb),
        .wb_val   (rx_wb_val),
        .ev       (rx_ev)
    );

    // R10
    rx_drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_en && !rx_ctl[ST_OWN]) |=> int_src[EV_BUSY]);

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_src == '0) |-> !irq);

endmodule

// File: tb/test_bd_ring_engine.sv
// Directed bench for bd_ring_engine: one task per scenario.
module test_bd_ring_engine;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              tx_req;
    logic [15:0]       tx_len;
    logic [31:0]       tx_addr;
    logic              tx_done = 1'b0;
    logic [8:0]        tx_result = '0;
    logic              tx_ctl_sent = 1'b0;
    logic              rx_valid = 1'b0;
    logic [15:0]       rx_len = '0;
    logic [8:0]        rx_flags = '0;
    logic              irq;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    bd_ring_engine #(.MAX_BD(128), .ADDR_W(ADDR_W)) i_bd_ring_engine (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_req(tx_req),
        .tx_len(tx_len), .tx_addr(tx_addr), .tx_done(tx_done),
        .tx_result(tx_result), .tx_ctl_sent(tx_ctl_sent), .rx_valid(rx_valid),
        .rx_len(rx_len), .rx_flags(rx_flags), .irq(irq)
    );

    localparam logic [ADDR_W-1:0] A_CTRL = 12'h000, A_ISRC = 12'h004,
                                  A_IMSK = 12'h008, A_TXCNT = 12'h020;

    function automatic logic [ADDR_W-1:0] dsc(int idx, int word);
        return ADDR_W'(32'h400 + 8 * idx + 4 * word);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd_chk(string req, string what, logic [ADDR_W-1:0] a, logic [31:0] exp);
        @(negedge clk);
        host_addr = a;
        #1 chk(req, what, host_rdata, exp);
    endtask

    task automatic expect_job(string req, logic [15:0] len, logic [31:0] addr);
        @(negedge clk);
        chk(req, "tx_req", 32'(tx_req), 32'd1);
        chk(req, "tx_len", 32'(tx_len), 32'(len));
        chk(req, "tx_addr", tx_addr, addr);
    endtask

    task automatic tx_finish(logic [8:0] res);
        @(negedge clk);
        tx_done = 1'b1; tx_result = res;
        @(negedge clk);
        tx_done = 1'b0; tx_result = '0;
    endtask

    task automatic rx_frame(logic [15:0] len, logic [8:0] flags);
        @(negedge clk);
        rx_valid = 1'b1; rx_len = len; rx_flags = flags;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1", "ctrl", A_CTRL, 32'h0);
        rd_chk("R1", "txcnt", A_TXCNT, 32'h40);
        rd_chk("R1", "isrc", A_ISRC, 32'h0);
        rd_chk("R1", "imsk", A_IMSK, 32'h0);
        rd_chk("R1", "desc0", dsc(0, 0), 32'h0);
        chk("R1", "irq", 32'(irq), 32'd0);
        chk("R1", "tx_req", 32'(tx_req), 32'd0);
    endtask

    task automatic t_table;
        wr(dsc(127, 0), 32'hA5A5_1234);
        wr(dsc(127, 1), 32'h0BAD_F00C);
        wr(dsc(5, 1), 32'h1357_9BDF);
        rd_chk("R3", "desc127 stat", dsc(127, 0), 32'hA5A5_1234);
        rd_chk("R3", "desc127 addr", dsc(127, 1), 32'h0BAD_F00C);
        rd_chk("R3", "desc5 addr", dsc(5, 1), 32'h1357_9BDF);
        rd_chk("R3", "desc5 stat", dsc(5, 0), 32'h0);
    endtask

    task automatic t_tx;
        wr(A_TXCNT, 32'd4);
        wr(A_IMSK, 32'h7F);
        wr(A_CTRL, 32'h2);
        wr(dsc(0, 1), 32'h0000_1000);
        wr(dsc(0, 0), 32'h0064_C800);
        chk("R4", "tx_req before pickup", 32'(tx_req), 32'd0);
        expect_job("R4", 16'd100, 32'h0000_1000);
        tx_finish(9'h030);
        chk("R5", "tx_req after done", 32'(tx_req), 32'd0);
        chk("R11", "irq after TXF", 32'(irq), 32'd1);
        rd_chk("R5", "desc0 writeback", dsc(0, 0), 32'h0064_4830);
        rd_chk("R6", "TXF source", A_ISRC, 32'h01);
        wr(A_ISRC, 32'h7F);
        // R7: desc2 ready while desc1 is not: no job may start
        wr(dsc(2, 1), 32'h0000_3000);
        wr(dsc(2, 0), 32'h0032_C000);
        repeat (5) @(negedge clk);
        chk("R7", "stall on desc1", 32'(tx_req), 32'd0);
        wr(dsc(1, 1), 32'h0000_2000);
        wr(dsc(1, 0), 32'h0028_F000);
        expect_job("R4", 16'd64, 32'h0000_2000);
        tx_finish(9'h100);
        rd_chk("R6", "TXE source", A_ISRC, 32'h02);
        rd_chk("R5", "desc1 writeback", dsc(1, 0), 32'h0028_7100);
        wr(A_ISRC, 32'h7F);
        // R8: WRAP on desc1 returns to desc0, so ready desc2 is not served
        repeat (3) @(negedge clk);
        chk("R8", "no job after WRAP", 32'(tx_req), 32'd0);
        wr(dsc(0, 1), 32'h0000_4000);
        wr(dsc(0, 0), 32'h001E_8000);
        expect_job("R8", 16'd30, 32'h0000_4000);
        tx_finish(9'h001);
        rd_chk("R6", "no event without IRQ", A_ISRC, 32'h00);
        rd_chk("R5", "desc0 error writeback", dsc(0, 0), 32'h001E_0001);
        wr(dsc(3, 1), 32'h0000_6000);
        wr(dsc(3, 0), 32'h0050_8000);
        wr(dsc(1, 1), 32'h0000_5000);
        wr(dsc(1, 0), 32'h0046_8000);
        expect_job("R7", 16'd70, 32'h0000_5000);
        tx_finish(9'h000);
        expect_job("R7", 16'd50, 32'h0000_3000);
        tx_finish(9'h000);
        rd_chk("R6", "TXF from desc2", A_ISRC, 32'h01);
        expect_job("R7", 16'd80, 32'h0000_6000);
        tx_finish(9'h000);
        repeat (3) @(negedge clk);
        chk("R8", "idle after last slot", 32'(tx_req), 32'd0);
        wr(dsc(0, 1), 32'h0000_7000);
        wr(dsc(0, 0), 32'h005A_8000);
        expect_job("R8", 16'd90, 32'h0000_7000);
        tx_finish(9'h000);
        wr(A_ISRC, 32'h7F);
        @(negedge clk);
        tx_ctl_sent = 1'b1;
        @(negedge clk);
        tx_ctl_sent = 1'b0;
        rd_chk("R6", "TXC source", A_ISRC, 32'h20);
        wr(A_ISRC, 32'h7F);
    endtask

    task automatic t_irq;
        wr(A_IMSK, 32'h00);
        @(negedge clk);
        tx_ctl_sent = 1'b1;
        @(negedge clk);
        tx_ctl_sent = 1'b0;
        rd_chk("R11", "latched while masked", A_ISRC, 32'h20);
        chk("R11", "irq masked", 32'(irq), 32'd0);
        wr(A_ISRC, 32'h00);
        rd_chk("R11", "write 0 keeps", A_ISRC, 32'h20);
        wr(A_IMSK, 32'h20);
        chk("R11", "irq unmasked", 32'(irq), 32'd1);
        wr(A_ISRC, 32'h20);
        rd_chk("R11", "write 1 clears", A_ISRC, 32'h00);
        chk("R11", "irq after clear", 32'(irq), 32'd0);
    endtask

    task automatic t_rx;
        wr(A_CTRL, 32'h0);
        wr(A_TXCNT, 32'h95);
        rd_chk("R2", "txcnt clamp", A_TXCNT, 32'h80);
        wr(A_CTRL, 32'h1);
        rx_frame(16'd64, 9'h000);
        rd_chk("R2", "no rx ring drop", A_ISRC, 32'h10);
        wr(A_ISRC, 32'h7F);
        wr(A_TXCNT, 32'd4);
        rd_chk("R2", "txcnt 4", A_TXCNT, 32'd4);
        wr(dsc(4, 1), 32'h0000_8000);
        wr(dsc(4, 0), 32'h0000_C000);
        wr(dsc(5, 0), 32'h0000_E000);
        rx_frame(16'd68, 9'h000);
        rd_chk("R9", "desc4 writeback", dsc(4, 0), 32'h0044_4000);
        rd_chk("R9", "desc4 addr kept", dsc(4, 1), 32'h0000_8000);
        rd_chk("R10", "RXF", A_ISRC, 32'h04);
        wr(A_ISRC, 32'h7F);
        rx_frame(16'd72, 9'h002);
        rd_chk("R9", "desc5 writeback", dsc(5, 0), 32'h0048_6002);
        rd_chk("R10", "RXE", A_ISRC, 32'h08);
        wr(A_ISRC, 32'h7F);
        rx_frame(16'd60, 9'h000);
        rd_chk("R10", "drop source", A_ISRC, 32'h10);
        rd_chk("R10", "desc4 untouched", dsc(4, 0), 32'h0044_4000);
        rd_chk("R10", "desc5 untouched", dsc(5, 0), 32'h0048_6002);
        wr(A_ISRC, 32'h7F);
        wr(dsc(4, 0), 32'h0000_C000);
        rx_frame(16'd80, 9'h100);
        rd_chk("R8", "rx wrap to desc4", dsc(4, 0), 32'h0050_4100);
        rd_chk("R10", "RXF and RXC", A_ISRC, 32'h44);
        wr(A_ISRC, 32'h7F);
        wr(dsc(5, 0), 32'h0000_E000);
        wr(A_CTRL, 32'h0);
        rx_frame(16'd90, 9'h000);
        rd_chk("R12", "disabled frame ignored", dsc(5, 0), 32'h0000_E000);
        rd_chk("R12", "no source when disabled", A_ISRC, 32'h00);
        wr(A_CTRL, 32'h1);
        wr(dsc(4, 0), 32'h0000_C000);
        rx_frame(16'd100, 9'h000);
        rd_chk("R12", "pointer back at desc4", dsc(4, 0), 32'h0064_4000);
        rd_chk("R12", "desc5 still empty", dsc(5, 0), 32'h0000_E000);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_table();
        t_tx();
        t_irq();
        t_rx();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule